// File: doc/BRIEF.md
# Far-End Receiver Detection Sequencer

This block sits in the fabric next to a PIPE-style transceiver lane and runs one far-end receiver detection pass on request. When a pass starts, the block puts the transmitter into electrical idle so that its output buffer is tri-stated. It holds that state for a guaranteed lead interval before it raises the detect request toward the PHY. It then waits for the PHY's completion strobe and classifies the 3-bit status that comes with it. The result is one of four outcomes: a receiver is present, the lane is empty, the status is a fault, or no answer came before the timeout.

A link-training controller pulses `start_req` and later reads a one-cycle `done_pulse` and a held `result` code. The lead interval is `LEAD_CYCLES` clocks, and any setting below 10 is raised to 10. The completion wait is bounded by `TIMEOUT_CYCLES` clocks of asserted request. Reset is synchronous and active high.

Top module: `rxdet_sequencer`

## Requirements
- R1: While `rst` is sampled high, and after it is released with no start, `tx_elec_idle`, `tx_detect_req`, `busy` and `done_pulse` are 0 and `result` is 0 (none).
- R2: A `start_req` sampled high while idle makes `tx_elec_idle` and `busy` high from the next cycle.
- R3: `tx_detect_req` rises exactly max(LEAD_CYCLES,10) cycles after `tx_elec_idle` rises, and `tx_elec_idle` stays high for as long as `tx_detect_req` is high.
- R4: A `phy_done` sampled while the request is high, with `phy_status` = 3'b011, gives `result` = 1 (present).
- R5: The same strobe with `phy_status` = 3'b000 gives `result` = 2 (absent).
- R6: Any other `phy_status` code sampled with the strobe gives `result` = 3 (fault).
- R7: In the cycle after the strobe is sampled, `tx_detect_req` and `tx_elec_idle` are 0 and `done_pulse` is 1 for exactly one cycle. The cycle after that, `busy` is 0.
- R8: If `tx_detect_req` has been high for TIMEOUT_CYCLES cycles with no strobe, it drops. `result` becomes 4 (timeout), `done_pulse` pulses once, and the block returns to idle.
- R9: A `start_req` while `busy` is high is ignored and does not change the timing of the pass in progress.
- R10: `result` holds its value while idle until the next accepted start, which clears it to 0.
- R11: A `phy_done` strobe while `tx_detect_req` is low has no effect on `result`, `done_pulse` or `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | Request one detection pass |
| phy_done | input | 1 | PHY completion strobe |
| phy_status | input | 3 | PHY status code, valid with `phy_done` |
| tx_elec_idle | output | 1 | Force transmitter electrical idle |
| tx_detect_req | output | 1 | Receiver-detect request to the PHY |
| busy | output | 1 | A pass is in progress |
| done_pulse | output | 1 | One-cycle end-of-pass marker |
| result | output | 3 | 0 none, 1 present, 2 absent, 3 fault, 4 timeout |

## Verification
The PHY responder answers with 3'b011, 3'b000 and two fault codes (3'b001, 3'b111), each after a different delay. This separates correct decoding from a decoder that only checks one bit or only one of the two valid codes. A silent responder exercises the timeout and shows the exact request length. Starts injected mid-pass and strobes sent outside a pass show whether the block reacts to inputs it should ignore. The lead count is checked on the cycle before and the cycle of the request edge, so an off-by-one is caught.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;

  typedef enum logic [2:0] {
    RES_NONE    = 3'd0,
    RES_PRESENT = 3'd1,
    RES_ABSENT  = 3'd2,
    RES_FAULT   = 3'd3,
    RES_TIMEOUT = 3'd4
  } rxdet_result_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FORCE_IDLE,
    ST_DETECT,
    ST_DONE,
    ST_TIMEOUT
  } rxdet_state_e;

  localparam logic [2:0] CODE_FOUND = 3'b011;
  localparam logic [2:0] CODE_EMPTY = 3'b000;
  localparam int unsigned MIN_LEAD  = 10;

  // Status code to outcome.
  function automatic rxdet_result_e classify(input logic [2:0] code);
    if (code == CODE_FOUND)      return RES_PRESENT;
    else if (code == CODE_EMPTY) return RES_ABSENT;
    else                         return RES_FAULT;
  endfunction

  // Lead interval never shorter than the buffer tri-state minimum.
  function automatic int unsigned lead_floor(input int unsigned req);
    return (req < MIN_LEAD) ? MIN_LEAD : req;
  endfunction

  // Counter width able to hold limit-1.
  function automatic int unsigned span_width(input int unsigned limit);
    return (limit < 3) ? 1 : $clog2(limit);
  endfunction

endpackage

// File: rtl/rxdet_span_counter.sv
module rxdet_span_counter #(
  parameter int unsigned LIMIT = 10,
  localparam int unsigned W = rxdet_pkg::span_width(LIMIT)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic hit
);
  logic [W-1:0] cnt;

  assign hit = run && (cnt == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (!hit)   cnt <= cnt + 1'b1;
  end

  // Counter never runs past its terminal value.
  assert_count_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= W'(LIMIT - 1)));
endmodule

// File: rtl/rxdet_status_decode.sv
module rxdet_status_decode (
  input  logic [2:0]                 code,
  output rxdet_pkg::rxdet_result_e   outcome,
  output logic                       is_found,
  output logic                       is_empty,
  output logic                       is_fault
);
  import rxdet_pkg::*;

  assign outcome  = classify(code);
  assign is_found = (outcome == RES_PRESENT);
  assign is_empty = (outcome == RES_ABSENT);
  assign is_fault = (outcome == RES_FAULT);

  // Exactly one class per code.
  always_comb begin
    assert_one_class_R6: assert ($countones({is_found, is_empty, is_fault}) == 1);
  end
endmodule

// File: rtl/rxdet_sequencer.sv
module rxdet_sequencer #(
  parameter int unsigned LEAD_CYCLES    = 10,
  parameter int unsigned TIMEOUT_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_req,
  input  logic       phy_done,
  input  logic [2:0] phy_status,
  output logic       tx_elec_idle,
  output logic       tx_detect_req,
  output logic       busy,
  output logic       done_pulse,
  output logic [2:0] result
);
  import rxdet_pkg::*;

  localparam int unsigned LEAD_EFF = lead_floor(LEAD_CYCLES);
  localparam int unsigned RUN_W    = span_width(LEAD_EFF + TIMEOUT_CYCLES + 2) + 1;

  rxdet_state_e  state, state_nx;
  rxdet_result_e res_q, res_nx;
  rxdet_result_e decoded;
  logic          dec_found, dec_empty, dec_fault;

  // Named internal events.
  logic start_accept, lead_hit, wait_hit, status_take, wait_expire;

  rxdet_span_counter #(.LIMIT(LEAD_EFF)) u_lead (
    .clk(clk), .rst(rst), .run(state == ST_FORCE_IDLE), .hit(lead_hit));

  rxdet_span_counter #(.LIMIT(TIMEOUT_CYCLES)) u_wait (
    .clk(clk), .rst(rst), .run(state == ST_DETECT), .hit(wait_hit));

  rxdet_status_decode u_dec (
    .code(phy_status), .outcome(decoded),
    .is_found(dec_found), .is_empty(dec_empty), .is_fault(dec_fault));

  assign start_accept = (state == ST_IDLE) && start_req;
  assign status_take  = (state == ST_DETECT) && phy_done;
  assign wait_expire  = (state == ST_DETECT) && !phy_done && wait_hit;

  always_comb begin
    state_nx = state;
    res_nx   = res_q;
    unique case (state)
      ST_IDLE:       if (start_accept) begin state_nx = ST_FORCE_IDLE; res_nx = RES_NONE; end
      ST_FORCE_IDLE: if (lead_hit) state_nx = ST_DETECT;
      ST_DETECT: begin
        if (status_take) begin
          state_nx = ST_DONE;
          res_nx   = decoded;
        end else if (wait_expire) begin
          state_nx = ST_TIMEOUT;
          res_nx   = RES_TIMEOUT;
        end
      end
      ST_DONE:       state_nx = ST_IDLE;
      ST_TIMEOUT:    state_nx = ST_IDLE;
      default:       state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      res_q <= RES_NONE;
    end else begin
      state <= state_nx;
      res_q <= res_nx;
    end
  end

  assign tx_elec_idle  = (state == ST_FORCE_IDLE) || (state == ST_DETECT);
  assign tx_detect_req = (state == ST_DETECT);
  assign busy          = (state != ST_IDLE);
  assign done_pulse    = (state == ST_DONE) || (state == ST_TIMEOUT);
  assign result        = res_q;

  // Checker counters: length of the current idle stretch and request stretch.
  logic [RUN_W-1:0] idle_run, req_run;
  always_ff @(posedge clk) begin
    if (rst) begin
      idle_run <= '0;
      req_run  <= '0;
    end else begin
      idle_run <= tx_elec_idle  ? ((idle_run == '1) ? idle_run : idle_run + 1'b1) : '0;
      req_run  <= tx_detect_req ? ((req_run  == '1) ? req_run  : req_run  + 1'b1) : '0;
    end
  end

  assert_idle_lead_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_detect_req) |-> (idle_run == RUN_W'(LEAD_EFF)));

  assert_req_under_idle_R3: assert property (@(posedge clk) disable iff (rst)
    tx_detect_req |-> tx_elec_idle);

  assert_start_raises_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_req) |=> (tx_elec_idle && !tx_detect_req));

  assert_drop_after_status_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_detect_req && phy_done) |=> (!tx_detect_req && !tx_elec_idle && done_pulse));

  assert_single_done_R7: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> (!done_pulse && !busy));

  assert_wait_bounded_R8: assert property (@(posedge clk) disable iff (rst)
    tx_detect_req |-> (req_run < RUN_W'(TIMEOUT_CYCLES)));

  assert_result_held_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_req) |=> $stable(result));

  assert_found_code_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_detect_req && phy_done && phy_status == 3'b011) |=> (result == 3'd1));
endmodule

// File: tb/tb_rxdet_sequencer.sv
module tb_rxdet_sequencer;
  localparam int unsigned LEAD = 10;
  localparam int unsigned TMO  = 48;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_req = 1'b0;
  logic       phy_done = 1'b0;
  logic [2:0] phy_status = 3'b000;
  logic       tx_elec_idle, tx_detect_req, busy, done_pulse;
  logic [2:0] result;

  int errors = 0;
  int checks = 0;

  rxdet_sequencer #(.LEAD_CYCLES(LEAD), .TIMEOUT_CYCLES(TMO)) dut (
    .clk(clk), .rst(rst), .start_req(start_req), .phy_done(phy_done),
    .phy_status(phy_status), .tx_elec_idle(tx_elec_idle),
    .tx_detect_req(tx_detect_req), .busy(busy), .done_pulse(done_pulse),
    .result(result));

  always #4 clk = ~clk;

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  // Expected outcome from the status code, restated from the requirements.
  function automatic int expect_code(input logic [2:0] s);
    case (s)
      3'b011:  return 1;
      3'b000:  return 2;
      default: return 3;
    endcase
  endfunction

  // Start a pass and walk through the lead interval; returns with detect just seen high.
  task automatic launch(input string tag, input bit poke_busy);
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    check({tag, " R2 idle"}, tx_elec_idle, 1);
    check({tag, " R2 busy"}, busy, 1);
    for (int i = 1; i < LEAD; i++) begin
      if (poke_busy && i == 4) start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
    end
    check({tag, " R3 req before lead"}, tx_detect_req, 0);
    @(negedge clk);
    check({tag, " R3 req at lead"}, tx_detect_req, 1);
    check({tag, " R3 idle with req"}, tx_elec_idle, 1);
  endtask

  task automatic answer(input string tag, input int delay, input logic [2:0] code, input bit poke_busy);
    launch(tag, poke_busy);
    for (int i = 0; i < delay; i++) begin
      if (poke_busy) start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
    end
    phy_done = 1'b1; phy_status = code;
    @(negedge clk);
    phy_done = 1'b0; phy_status = 3'b000;
    check({tag, " R7 req dropped"}, tx_detect_req, 0);
    check({tag, " R7 idle dropped"}, tx_elec_idle, 0);
    check({tag, " R7 done"}, done_pulse, 1);
    check({tag, " R4/R5/R6 result"}, result, expect_code(code));
    @(negedge clk);
    check({tag, " R7 single pulse"}, done_pulse, 0);
    check({tag, " R7 not busy"}, busy, 0);
    check({tag, " R10 held"}, result, expect_code(code));
  endtask

  task automatic run_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle", tx_elec_idle, 0);
    check("R1 req", tx_detect_req, 0);
    check("R1 busy", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done", done_pulse, 0);
    check("R1 result", result, 0);
  endtask

  task automatic run_timeout;
    launch("timeout", 1'b0);
    for (int j = 1; j < TMO; j++) @(negedge clk);
    check("R8 req at limit", tx_detect_req, 1);
    @(negedge clk);
    check("R8 req dropped", tx_detect_req, 0);
    check("R8 done", done_pulse, 1);
    check("R8 result", result, 4);
    @(negedge clk);
    check("R8 back idle", busy, 0);
  endtask

  task automatic run_stray_strobe;
    phy_done = 1'b1; phy_status = 3'b011;
    @(negedge clk);
    phy_done = 1'b0; phy_status = 3'b000;
    check("R11 no done", done_pulse, 0);
    check("R11 not busy", busy, 0);
    check("R11 result kept", result, 4);
    @(negedge clk);
    check("R11 result kept later", result, 4);
  endtask

  task automatic run_clear_on_start;
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    check("R10 cleared on start", result, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset mid pass", busy, 0);
  endtask

  initial begin
    run_reset();
    answer("present", 3, 3'b011, 1'b0);
    answer("absent",  0, 3'b000, 1'b0);
    answer("fault1",  7, 3'b001, 1'b0);
    answer("fault7",  1, 3'b111, 1'b0);
    answer("R9 busy start", 5, 3'b011, 1'b1);
    run_timeout();
    run_stray_strobe();
    run_clear_on_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule